// File: doc/BRIEF.md
# Transfer Counter with Half-Way Status

This block keeps the transfer count of one DMA channel. Software loads a starting count while the channel is idle and then turns the channel on. From then on, every pulse on the transfer strobe takes one off the live count. When the count runs out, a finish flag is set and the channel stops counting. An optional half-way flag marks the moment the live count drops to half of the starting value. That point is found by shifting the starting count right by one bit, so an odd start rounds down. A starting count of zero stands for the full range of 2^CNT_W transfers, and its half-way point is 2^(CNT_W-1).

The half-way flag follows strict rules. Stopping the channel does not set it. Once it is set, stopping the channel does not clear it. Software can clear it only by first reading it as 1 and then writing 0. The `HALF_EN` parameter leaves the feature out on channels that do not carry it. Both flags drive level interrupt requests, each gated by its own enable bit.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the count reads 0, every control bit reads 0, and both interrupt outputs are low.
- R2: Writing the count register (`reg_sel`=0) loads `wr_data[CNT_W-1:0]` into the live count only while the channel enable (control bit 0) is 0. Such a write is ignored while the channel is enabled. Reading with `reg_sel`=0 returns the count in the low bits and zeros above them.
- R3: The live count goes down by exactly one on each `dec_strobe` cycle in which the channel is enabled, `gbl_en` is 1, the finish flag is 0 and neither abort input is high. In every other cycle the count holds.
- R4: The starting count is captured when a control write (`reg_sel`=1) turns control bit 0 from 0 to 1. The half-way mark is that starting count shifted right by one bit, or 2^(CNT_W-1) for a start of 0. The half-way flag (control bit 3) is set in the cycle a decrement makes the live count equal to the mark, provided the half-way interrupt enable (control bit 1) is 1 in that cycle.
- R5: A decrement that reaches the mark while control bit 1 is 0 leaves the half-way flag at 0.
- R6: `nmi_abort` or `addr_err` clears the channel enable and blocks a strobe in the same cycle. A low `gbl_en` blocks strobes. Writing 0 to control bit 0 stops the channel. Any of these events before the mark is reached leaves the half-way flag at 0.
- R7: Once the half-way flag is set, the events of R6 leave it set.
- R8: A control read that returns bit 3 as 1 arms a clear. The next control write consumes that arm, and it clears the flag only if its bit 3 is 0. A write of 0 without the arm is ignored, and writing 1 never sets the flag.
- R9: The decrement that reaches 0 sets the finish flag (control bit 4). After that, strobes are ignored until a control write with bit 4 = 0 clears the flag. Writing 1 to bit 4 has no effect.
- R10: `end_irq` is the finish flag ANDed with control bit 2. `half_irq` is the half-way flag ANDed with control bit 1. Both are levels.
- R11: With `HALF_EN`=0, control bit 3 always reads 0 and `half_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the clear) |
| reg_sel | input | 1 | 0 selects the count, 1 selects control/status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| dec_strobe | input | 1 | One pulse per completed transfer |
| nmi_abort | input | 1 | Non-maskable interrupt stop |
| addr_err | input | 1 | Address error stop |
| gbl_en | input | 1 | Global DMA enable level |
| end_irq | output | 1 | Finish interrupt request |
| half_irq | output | 1 | Half-way interrupt request |

## Verification
The assertions assume that a register read and a register write never happen in the same cycle. They also assume that an abort input never coincides with a control write, because the order in which those two act is not part of the contract. The stimulus issues one register access per cycle, puts aborts only on cycles without register access, and loads counts only while the channel is off. A behavioural model in the bench follows every input each cycle and checks the read data and both interrupt levels. A second instance built without the half-way feature receives the same stimulus.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  // control/status bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_HIE = 1;
  localparam int BIT_EIE = 2;
  localparam int BIT_HF  = 3;
  localparam int BIT_EF  = 4;
  localparam int CTRL_W  = 5;

  // half-way mark: start shifted right once, zero start means full range
  function automatic logic [31:0] half_mark(input logic [31:0] start, input int unsigned w);
    if (start == 32'd0) return 32'd1 << (w - 1);
    return start >> 1;
  endfunction
endpackage

// File: rtl/xcu_counter.sv
module xcu_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en_rise,
  input  logic             dec_fire,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] start_cnt,
  output logic             hit_half,
  output logic             hit_zero
);
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] mark;

  assign cnt_nxt  = cnt - 1'b1;
  assign mark     = CNT_W'(xcu_pkg::half_mark(32'(start_cnt), CNT_W));
  assign hit_half = dec_fire && (cnt_nxt == mark);
  assign hit_zero = dec_fire && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      start_cnt <= '0;
    end else begin
      if (load_we)       cnt <= load_val;
      else if (dec_fire) cnt <= cnt_nxt;
      if (en_rise)       start_cnt <= cnt;
    end
  end
endmodule

// File: rtl/xcu_half_flag.sv
module xcu_half_flag #(
  parameter bit HALF_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wr_bit,
  output logic flag
);
  if (HALF_EN) begin : g_on
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (set_req)                          flag <= 1'b1;
        else if (wr_ctrl && !wr_bit && armed) flag <= 1'b0;
        if (wr_ctrl)              armed <= 1'b0;
        else if (rd_ctrl && flag) armed <= 1'b1;
      end
    end
  end else begin : g_off
    logic unused_in;
    assign unused_in = ^{clk, rst_n, set_req, rd_ctrl, wr_ctrl, wr_bit};
    assign flag = 1'b0;
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int CNT_W   = 24,
  parameter bit HALF_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        dec_strobe,
  input  logic        nmi_abort,
  input  logic        addr_err,
  input  logic        gbl_en,
  output logic        end_irq,
  output logic        half_irq
);
  import xcu_pkg::*;

  logic chan_en, half_ie, end_ie, end_flag, half_flag;
  logic wr_ctrl, wr_cnt, rd_ctrl, abort_ev, en_rise, dec_fire;
  logic hit_half, hit_zero;
  logic [CNT_W-1:0] cnt, start_cnt;
  logic [CTRL_W-1:0] ctrl_word;
  logic unused_bits;

  // named internal events
  assign wr_ctrl  = reg_wr && reg_sel;
  assign rd_ctrl  = reg_rd && reg_sel;
  assign wr_cnt   = reg_wr && !reg_sel && !chan_en;
  assign abort_ev = nmi_abort || addr_err;
  assign en_rise  = wr_ctrl && wr_data[BIT_EN] && !chan_en && !abort_ev;
  assign dec_fire = chan_en && gbl_en && !end_flag && dec_strobe && !abort_ev;

  xcu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load_we(wr_cnt), .load_val(wr_data[CNT_W-1:0]),
    .en_rise(en_rise), .dec_fire(dec_fire),
    .cnt(cnt), .start_cnt(start_cnt),
    .hit_half(hit_half), .hit_zero(hit_zero)
  );

  xcu_half_flag #(.HALF_EN(HALF_EN)) u_hf (
    .clk(clk), .rst_n(rst_n),
    .set_req(hit_half && half_ie),
    .rd_ctrl(rd_ctrl), .wr_ctrl(wr_ctrl), .wr_bit(wr_data[BIT_HF]),
    .flag(half_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      half_ie  <= 1'b0;
      end_ie   <= 1'b0;
      end_flag <= 1'b0;
    end else begin
      if (abort_ev)     chan_en <= 1'b0;
      else if (wr_ctrl) chan_en <= wr_data[BIT_EN];
      if (wr_ctrl) begin
        half_ie <= wr_data[BIT_HIE];
        end_ie  <= wr_data[BIT_EIE];
      end
      if (hit_zero)                         end_flag <= 1'b1;
      else if (wr_ctrl && !wr_data[BIT_EF]) end_flag <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[BIT_EN]  = chan_en;
    ctrl_word[BIT_HIE] = half_ie;
    ctrl_word[BIT_EIE] = end_ie;
    ctrl_word[BIT_HF]  = half_flag;
    ctrl_word[BIT_EF]  = end_flag;
  end

  assign rd_data  = reg_sel ? 32'(ctrl_word) : 32'(cnt);
  assign end_irq  = end_flag && end_ie;
  assign half_irq = half_flag && half_ie;
  assign unused_bits = ^{wr_data, reg_rd};
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
  parameter int CNT_W   = 24,
  parameter bit HALF_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_abort,
  input logic             addr_err,
  input logic             wr_ctrl,
  input logic             wr_cnt,
  input logic             wr_bit3,
  input logic             dec_fire,
  input logic             chan_en,
  input logic             half_ie,
  input logic             half_flag,
  input logic             end_flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_cnt
);
  logic [CNT_W-1:0] exp_mark;
  assign exp_mark = (start_cnt == '0) ? {1'b1, {(CNT_W-1){1'b0}}} : (start_cnt / 2);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> cnt == $past(cnt) - 1'b1);
  a_r4_shadow_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(start_cnt));
  a_r4_set_at_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_flag) |-> (cnt == exp_mark) && $past(half_ie));
  a_r6_abort_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_abort || addr_err) |=> !$rose(half_flag));
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (half_flag && !wr_ctrl) |=> half_flag);
  a_r8_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_flag) |-> $past(wr_ctrl && !wr_bit3));
  a_r9_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> cnt == '0);
  a_r9_end_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !wr_cnt) |=> $stable(cnt));

  if (!HALF_EN) begin : g_nh
    a_r11_no_flag: assert property (@(posedge clk) disable iff (!rst_n) !half_flag);
  end
endmodule

bind xfer_count_unit xcu_checker #(.CNT_W(CNT_W), .HALF_EN(HALF_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_abort(nmi_abort), .addr_err(addr_err),
  .wr_ctrl(wr_ctrl), .wr_cnt(wr_cnt), .wr_bit3(wr_data[3]), .dec_fire(dec_fire),
  .chan_en(chan_en), .half_ie(half_ie), .half_flag(half_flag), .end_flag(end_flag),
  .cnt(cnt), .start_cnt(start_cnt)
);

// File: tb/tb_xfer_count_unit.sv
`timescale 1ns/1ps
module tb_xfer_count_unit;
  localparam int W = 10;
  localparam int MAXC = 1 << W;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0, dec_strobe = 0, nmi_abort = 0, addr_err = 0, gbl_en = 1;
  logic [31:0] wr_data = 0, rd_data, rd_nh;
  logic end_irq, half_irq, end_nh, half_nh;

  always #10 clk = ~clk;

  xfer_count_unit #(.CNT_W(W), .HALF_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .dec_strobe(dec_strobe), .nmi_abort(nmi_abort),
    .addr_err(addr_err), .gbl_en(gbl_en), .end_irq(end_irq), .half_irq(half_irq));

  xfer_count_unit #(.CNT_W(W), .HALF_EN(1'b0)) dut_nh (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_nh), .dec_strobe(dec_strobe), .nmi_abort(nmi_abort),
    .addr_err(addr_err), .gbl_en(gbl_en), .end_irq(end_nh), .half_irq(half_nh));

  // behavioural reference state
  int m_cnt = 0, m_start = 0;
  bit m_en = 0, m_hie = 0, m_eie = 0, m_hf = 0, m_ef = 0, m_arm = 0;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [31:0] last_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mark_of(input int s);
    if (s == 0) return MAXC / 2;
    return s / 2;
  endfunction

  function automatic logic [31:0] model_word(input bit sel, input bit with_hf);
    if (!sel) return 32'(m_cnt);
    return {27'd0, m_ef, m_hf & with_hf, m_eie, m_hie, m_en};
  endfunction

  // one clock: compare levels, drive, compare read data, advance the model
  task automatic cyc(input bit wr, input bit rd, input bit sel, input int wd,
                     input bit strobe, input bit nmi, input bit ae, input bit ge);
    bit ab, fire, hh, zh, n_hf, n_arm, n_ef, n_en;
    int nxt;
    @(negedge clk);
    chk("R10 end_irq", 32'(end_irq), 32'(m_ef & m_eie));
    chk("R10 half_irq", 32'(half_irq), 32'(m_hf & m_hie));
    chk("R11 half_irq", 32'(half_nh), 32'd0);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; wr_data = 32'(wd);
    dec_strobe = strobe; nmi_abort = nmi; addr_err = ae; gbl_en = ge;
    #2;
    last_rd = rd_data;
    if (rd) begin
      chk("R2/R9 read", rd_data, model_word(sel, 1'b1));
      chk("R11 read", rd_nh, model_word(sel, 1'b0));
    end
    @(posedge clk);
    ab   = nmi | ae;
    fire = m_en && ge && !m_ef && strobe && !ab;
    nxt  = (m_cnt + MAXC - 1) % MAXC;
    hh   = fire && (nxt == mark_of(m_start));
    zh   = fire && (m_cnt == 1);
    n_hf  = (hh && m_hie) ? 1'b1 : ((wr && sel && !wd[3] && m_arm) ? 1'b0 : m_hf);
    n_arm = (wr && sel) ? 1'b0 : ((rd && sel && m_hf) ? 1'b1 : m_arm);
    n_ef  = zh ? 1'b1 : ((wr && sel && !wd[4]) ? 1'b0 : m_ef);
    n_en  = ab ? 1'b0 : ((wr && sel) ? wd[0] : m_en);
    if (wr && sel && wd[0] && !m_en && !ab) m_start = m_cnt;
    if (wr && !sel && !m_en) m_cnt = wd % MAXC;
    else if (fire) m_cnt = nxt;
    if (wr && sel) begin m_hie = wd[1]; m_eie = wd[2]; end
    m_hf = n_hf; m_arm = n_arm; m_ef = n_ef; m_en = n_en;
  endtask

  task automatic idle();                  cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic wr_reg(input bit s, input int v); cyc(1, 0, s, v, 0, 0, 0, 1); endtask
  task automatic rd_reg(input bit s);      cyc(0, 1, s, 0, 0, 0, 0, 1); endtask
  task automatic strobes(input int n, input bit ge);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0, ge);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(1); chk("R1 ctrl", last_rd, 32'h0);
    rd_reg(0); chk("R1 count", last_rd, 32'h0);
    // R2 load while idle, ignored while enabled
    wr_reg(0, 10); wr_reg(1, 'h7); wr_reg(0, 99);
    rd_reg(0); chk("R2 count kept", last_rd, 32'd10);
    // R3 decrement, R4 even start mark 5
    strobes(4, 1); rd_reg(0); chk("R3 count", last_rd, 32'd6);
    strobes(1, 1); rd_reg(1); chk("R4 even mark", last_rd, 32'h0F);
    idle(); chk("R10 half level", 32'(half_irq), 32'd1);
    // R8 arm consumed by a write that keeps bit3
    wr_reg(1, 'h0F); wr_reg(1, 'h07);
    rd_reg(1); chk("R8 unarmed zero ignored", last_rd, 32'h0F);
    wr_reg(1, 'h07); rd_reg(1); chk("R8 armed clear", last_rd, 32'h07);
    wr_reg(1, 'h0F); rd_reg(1); chk("R8 one never sets", last_rd, 32'h07);
    // R9 end of count
    strobes(5, 1); rd_reg(1); chk("R9 end flag", last_rd, 32'h17);
    idle(); chk("R9 end_irq", 32'(end_irq), 32'd1);
    strobes(3, 1); rd_reg(0); chk("R9 frozen", last_rd, 32'd0);
    wr_reg(1, 0); rd_reg(1); chk("R9 cleared", last_rd, 32'h0);
    // R4 odd start 7 -> mark 3
    wr_reg(0, 7); wr_reg(1, 'h3); strobes(3, 1);
    rd_reg(1); chk("R4 odd before", last_rd, 32'h03);
    strobes(1, 1); rd_reg(1); chk("R4 odd mark", last_rd, 32'h0B);
    wr_reg(1, 0); rd_reg(1); chk("R8 clear", last_rd, 32'h0);
    // R5 enable off at the mark
    wr_reg(0, 8); wr_reg(1, 'h1); strobes(4, 1); wr_reg(1, 'h3);
    rd_reg(1); chk("R5 no flag", last_rd, 32'h03);
    wr_reg(1, 0);
    // R6 aborts before the mark
    wr_reg(0, 20); wr_reg(1, 'h3); strobes(3, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1);
    rd_reg(1); chk("R6 nmi stop", last_rd, 32'h02);
    strobes(10, 1); rd_reg(0); chk("R6 nmi count", last_rd, 32'd17);
    wr_reg(1, 'h3); cyc(0, 0, 0, 0, 1, 0, 1, 1);
    rd_reg(0); chk("R6 addr err", last_rd, 32'd17);
    wr_reg(1, 'h3); strobes(12, 0);
    rd_reg(0); chk("R6 global off", last_rd, 32'd17);
    wr_reg(1, 'h2); strobes(12, 1);
    rd_reg(0); chk("R6 chan clear", last_rd, 32'd17);
    rd_reg(1); chk("R6 no flag", last_rd, 32'h02);
    wr_reg(1, 0);
    // R7 aborts after the flag
    wr_reg(0, 6); wr_reg(1, 'h3); strobes(3, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1);
    rd_reg(1); chk("R7 held nmi", last_rd, 32'h0A);
    strobes(4, 0); rd_reg(1); chk("R7 held global", last_rd, 32'h0A);
    wr_reg(1, 0);
    // R4 zero start: full range, mark 2^(W-1)
    wr_reg(0, 0); wr_reg(1, 'h7); strobes(511, 1);
    rd_reg(1); chk("R4 zero before", last_rd, 32'h07);
    strobes(1, 1); rd_reg(1); chk("R4 zero mark", last_rd, 32'h0F);
    rd_reg(0); chk("R4 zero count", last_rd, 32'd512);
    strobes(512, 1); rd_reg(1); chk("R9 full range end", last_rd, 32'h1F);
    wr_reg(1, 0); rd_reg(1); chk("R8 final clear", last_rd, 32'h0);
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule